// File: doc/BRIEF.md
# Supply Level Request Controller

This block asks an external regulator for one of eight discrete supply levels and then confirms that the regulator really moved there. A request carries a logical level number. The block turns that number into the regulator's encoded level. It issues a single register write that carries the encoded level and an enable flag, then waits a settle time given in clock cycles. After the wait it compares the level the regulator reports against the encoded target.

The reported level arrives from another domain, so it is resynchronised before use. The outcome is a one-cycle `done` pulse when the levels agree, or a one-cycle `err` pulse when they differ. Only one request is handled at a time, and `busy` marks that window. The analog behaviour of the regulator lies outside the block.

Top module: `supply_level_req`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `err` and `wr_en` are low and `wr_data` is zero.
- R2: A request accepted while idle produces exactly one cycle of `wr_en`, visible right after the accepting edge. In that cycle `wr_data` bit 7 is 1, bits [5:3] hold the encoded level, and every other bit is 0.
- R3: Level encoding: logical levels 0, 1 and 2 encode as themselves, levels 3, 4, 5 and 6 all encode as 3, and level 7 encodes as 7.
- R4: Let the request be accepted at edge E0 with settle value N, a 16-bit cycle count sampled at acceptance. The result pulse is then visible right after edge E0+N+1, so N = 0 gives a check on the very next cycle.
- R5: At the check, the synchronised regulator level `stat_level` (bits [2:0] of the level register) is compared with the encoded target. Equal values raise `done`; unequal values raise `err`.
- R6: `done` and `err` are never high together, and each is high for one cycle only.
- R7: `busy` is high from the accepting edge until the result edge. A request presented while busy is ignored and produces no write and no change to the pending result.
- R8: `stat_level` passes through two flip-flops before the comparison. A change the regulator makes at edge E1 is therefore first seen by a check at edge E4, so a settle value of 2 compares the previous level.
- R9: A reset while a request is pending cancels it, and no result pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_level | input | 3 | Logical level requested |
| settle_cycles | input | 16 | Settle wait in cycles, sampled at acceptance |
| stat_level | input | 3 | Level currently reported by the regulator |
| wr_en | output | 1 | Level register write strobe |
| wr_data | output | 8 | Level register write word |
| busy | output | 1 | Request in flight |
| done | output | 1 | Readback matched, one-cycle pulse |
| err | output | 1 | Readback mismatch, one-cycle pulse |

## Verification
The bench builds the block with its default parameters: 8-bit register word, 3-bit level, 16-bit settle counter and two synchroniser stages. With two stages, settle values of 2 and 3 sit on either side of the point where a fresh regulator level becomes visible to the check. This lets the bench show that short waits compare the old level. The 16-bit counter allows a long wait of 300 cycles next to the zero-wait case. A regulator model that can ignore writes or corrupt them makes the error path reachable.

// File: rtl/slr_pkg.sv
package slr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1
  } slr_state_t;
endpackage

// File: rtl/slr_sync.sv
module slr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/slr_level_enc.sv
module slr_level_enc #(
  parameter int LVL_W    = 3,
  parameter int CLAMP_LO = 3,
  parameter int CLAMP_HI = 6
) (
  input  logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] code
);
  localparam logic [LVL_W-1:0] LO = LVL_W'(CLAMP_LO);
  localparam logic [LVL_W-1:0] HI = LVL_W'(CLAMP_HI);

  always_comb begin
    if (level >= LO && level <= HI) code = LO;
    else                            code = level;
  end
endmodule

// File: rtl/slr_settle_timer.sv
module slr_settle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/supply_level_req.sv
module supply_level_req #(
  parameter int REG_W       = 8,
  parameter int LVL_W       = 3,
  parameter int LVL_LSB     = 3,
  parameter int EN_BIT      = 7,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [LVL_W-1:0] req_level,
  input  logic [CNT_W-1:0] settle_cycles,
  input  logic [LVL_W-1:0] stat_level,
  output logic             wr_en,
  output logic [REG_W-1:0] wr_data,
  output logic             busy,
  output logic             done,
  output logic             err
);
  import slr_pkg::*;

  localparam int LVL_MSB = LVL_LSB + LVL_W - 1;

  slr_state_t       state_q;
  logic [LVL_W-1:0] target_q;
  logic [LVL_W-1:0] enc_level;
  logic [LVL_W-1:0] stat_sync;
  logic             accept;
  logic             timer_expired;
  logic [REG_W-1:0] word_next;

  assign accept = (state_q == ST_IDLE) && req_valid;

  slr_level_enc #(.LVL_W(LVL_W), .CLAMP_LO(3), .CLAMP_HI(6)) enc_i (
    .level (req_level),
    .code  (enc_level)
  );

  slr_sync #(.W(LVL_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (stat_level),
    .q   (stat_sync)
  );

  slr_settle_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (settle_cycles),
    .run      (state_q == ST_WAIT),
    .expired  (timer_expired)
  );

  always_comb begin
    word_next                    = '0;
    word_next[EN_BIT]            = 1'b1;
    word_next[LVL_MSB:LVL_LSB]   = enc_level;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      target_q <= '0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            target_q <= enc_level;
            wr_en    <= 1'b1;
            wr_data  <= word_next;
            busy     <= 1'b1;
            state_q  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (timer_expired) begin
            if (stat_sync == target_q) done <= 1'b1;
            else                       err  <= 1'b1;
            busy    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en); // R2
  AST_WR_FLAG: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_data[EN_BIT]); // R2
  AST_WR_CODE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data[LVL_MSB:LVL_LSB] <= LVL_W'(3) ||
               wr_data[LVL_MSB:LVL_LSB] == {LVL_W{1'b1}})); // R3
  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && err)); // R6
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    (done || err) |=> !(done || err)); // R6
  AST_WR_BUSY: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy); // R7
  AST_RESULT_FREE: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> !busy); // R7
  AST_NO_REWRITE: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !wr_en); // R7
endmodule

// File: tb/supply_level_req_tb.sv
module supply_level_req_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_level = '0;
  logic [15:0] settle_cycles = '0;
  logic [2:0]  stat_level;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic        busy, done, err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [1:0] fault = 2'd0;   // 0 obey, 1 ignore writes, 2 corrupt lsb
  logic [2:0] reg_level = 3'd0;

  // expected encoding per R3, index = logical level
  localparam logic [2:0] EXP_ENC [8] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd3, 3'd3, 3'd3, 3'd7};

  // {level, settle, fault, expect_err}
  localparam logic [21:0] VEC [NVEC] = '{
    {3'd5, 16'd4,   2'd0, 1'b0},
    {3'd7, 16'd3,   2'd0, 1'b0},
    {3'd0, 16'd0,   2'd0, 1'b1},
    {3'd2, 16'd10,  2'd0, 1'b0},
    {3'd6, 16'd5,   2'd1, 1'b1},
    {3'd3, 16'd2,   2'd0, 1'b1},
    {3'd4, 16'd2,   2'd0, 1'b0},
    {3'd1, 16'd6,   2'd2, 1'b1},
    {3'd6, 16'd300, 2'd0, 1'b0},
    {3'd1, 16'd3,   2'd0, 1'b0}
  };

  supply_level_req dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
    .settle_cycles(settle_cycles), .stat_level(stat_level),
    .wr_en(wr_en), .wr_data(wr_data), .busy(busy), .done(done), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // regulator model: takes the written level on the edge that sees wr_en
  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (fault == 2'd0)      reg_level <= wr_data[5:3];
      else if (fault == 2'd2) reg_level <= wr_data[5:3] ^ 3'd1;
    end
  end
  assign stat_level = reg_level;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [2:0] lvl, input logic [15:0] settle,
                         input logic [1:0] fm, input logic exp_err, input logic hold_busy);
    int n;
    logic seen;
    logic extra_wr;
    @(negedge clk);
    fault = fm; req_valid = 1'b1; req_level = lvl; settle_cycles = settle;
    @(negedge clk);
    if (hold_busy) req_level = ~lvl; else req_valid = 1'b0;
    check(wr_en == 1'b1, "R2 write strobe", wr_en, 1);
    check(wr_data == {1'b1, 1'b0, EXP_ENC[lvl], 3'b000}, "R2/R3 write word",
          wr_data, {1'b1, 1'b0, EXP_ENC[lvl], 3'b000});
    check(busy == 1'b1, "R7 busy after accept", busy, 1);
    n = 0; seen = 1'b0; extra_wr = 1'b0;
    while (!seen && n < 2000) begin
      @(negedge clk);
      n++;
      if (wr_en) extra_wr = 1'b1;
      if (done || err) begin
        seen = 1'b1;
        req_valid = 1'b0;
      end
    end
    req_valid = 1'b0;
    check(!extra_wr, "R2/R7 no further write", extra_wr, 0);
    check(n == int'(settle) + 1, "R4 result latency", n, int'(settle) + 1);
    check(err == exp_err && done == !exp_err, "R5/R8 outcome", {done, err}, {!exp_err, exp_err});
    check(!busy, "R7 busy cleared", busy, 0);
    @(negedge clk);
    check(!done && !err, "R6 single-cycle result", {done, err}, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy, done, err, wr_en} == 4'b0 && wr_data == 8'h00, "R1 reset state",
          {busy, done, err, wr_en, wr_data}, 0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++)
      run_req(VEC[i][21:19], VEC[i][18:3], VEC[i][2:1], VEC[i][0], 1'b0);

    // R7: requests held during the wait are ignored; regulator now at 1
    run_req(3'd7, 16'd20, 2'd0, 1'b0, 1'b1);

    // R9: reset while pending cancels the request
    @(negedge clk);
    fault = 2'd0; req_valid = 1'b1; req_level = 3'd2; settle_cycles = 16'd50;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check({busy, done, err, wr_en} == 4'b0, "R9 cleared by reset", {busy, done, err, wr_en}, 0);
    begin
      logic any_res = 1'b0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (done || err || wr_en) any_res = 1'b1;
      end
      check(!any_res, "R9 no result after cancel", any_res, 0);
    end
    // recovery: regulator took level 2, request it again
    run_req(3'd2, 16'd4, 2'd0, 1'b0, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule